// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a parallel NOR-style flash. It watches host write cycles (address, data, write strobe) and turns multi-cycle, unlock-prefixed sequences into actions. A standard program places one word, or one byte, into the array. The identification mode makes reads return the manufacturer code, the device code and per-sector protection status. The fast-program mode stays active and lets each later program drop its two unlock cycles.

A mode input selects word or byte addressing. In byte mode the unlock addresses change, and so do the identification offsets and the byte lane that a program touches. The array is modelled as a small register memory that is cleared to all ones at reset. A program operation occupies an internal engine for a fixed number of cycles. During that time every host write is dropped.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `id_mode`, `busy` and `prog_req` are 0, and every array word reads back as FFFFh.
- R2: In word mode the first unlock cycle is data AAh at address 555h and the second is data 55h at address 2AAh. In byte mode these addresses are AAAh and 555h. The command cycle that follows uses the first unlock address and carries the command in data bits 7:0. Only 11 address bits are compared in word mode and 12 in byte mode.
- R3: Unlock, unlock, then 90h sets `id_mode` to 1. It stays 1 for any number of reads and for any write whose low data byte is not F0h. A write of F0h at any address clears it.
- R4: While `id_mode` is 1, the read offset is `rd_addr[2:0]`. In word mode, offset 0 returns the manufacturer code and offset 1 returns the device code. In byte mode these are offsets 0 and 2. Byte mode returns only the low byte of a code, with bits 15:8 at zero. Every other offset reads 0, except the protection offset in R5.
- R5: While `id_mode` is 1, offset 2 in word mode, or offset 4 in byte mode, returns 1 if the addressed sector is protected and 0 if it is not. The sector is bits 5:4 of the word address, which is `rd_addr` in word mode and `rd_addr>>1` in byte mode. Sector n is protected when bit n of PROT_MASK is set.
- R6: Unlock, unlock, A0h, then a fourth write starts a program. On the edge that accepts the fourth write, `prog_req` rises for exactly one cycle. On the same edge, `prog_addr` and `prog_data` capture that write and then hold while `busy` is high.
- R7: `busy` rises on the accepting edge and stays high for PROG_CYCLES cycles. Any write that the clock samples while `busy` is high is ignored. This includes a write on the edge where `busy` falls.
- R8: Unlock, unlock, 20h enters fast-program mode. In that mode, A0h followed by one address/data write programs the array. The mode is still active after the program.
- R9: In fast-program mode every write other than A0h or 90h is ignored. If 90h is followed by a write that is not 00h, the block stays in fast-program mode.
- R10: In fast-program mode, 90h followed by 00h (addresses ignored) returns to array read. A later A0h and data write then program nothing.
- R11: A write that breaks a standard sequence, by wrong data or wrong address, returns the decoder to idle with no program and no mode change.
- R12: In byte mode, a program at byte address b changes only byte lane b[0] of word b>>1. Lane 0 is bits 7:0. A byte-mode read returns the selected lane in bits 7:0 with zeros above.
- R13: A program ANDs the data into the stored word, so bits can go from 1 to 0 but never back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| bus_we | input | 1 | Host write strobe, one write per sampled cycle |
| bus_addr | input | 12 | Host write address |
| bus_wdata | input | 16 | Host write data (commands in bits 7:0) |
| rd_addr | input | 12 | Read address |
| rd_data | output | 16 | Read data: array contents, or identification data while `id_mode` is 1 |
| id_mode | output | 1 | Read-mode select: 1 = identification, 0 = array |
| prog_req | output | 1 | One-cycle pulse when a program is accepted |
| prog_addr | output | 12 | Address latched for the current program |
| prog_data | output | 16 | Data latched for the current program |
| busy | output | 1 | The program engine is running |

## Verification
Two events can fall on the same clock edge: the program engine finishing, and a new host write arriving. The bench times an unlock write so that the edge which clears `busy` samples it. It then judges the write as dropped, because the rest of an identification sequence that follows leaves `id_mode` at 0. The same write placed one cycle later must be taken, and that sequence must set `id_mode`. Array reads are checked right after the commit edge, against a model in the bench that ANDs each program into the stored word.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BUS_AW = 12;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PSET, S_AUTO, S_BYP, S_BPROG, S_BRST
  } seq_state_e;

  typedef enum logic [1:0] {ID_MFR, ID_DEV, ID_PROT, ID_NONE} id_slot_e;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_FAST    = 8'h20;
  localparam logic [7:0] CMD_EXIT    = 8'hF0;
  localparam logic [7:0] CMD_FASTEND = 8'h00;

  // Address of unlock cycle (second=0: first cycle, second=1: second cycle).
  function automatic logic unlock_addr_hit(input logic [BUS_AW-1:0] a,
                                           input logic bm, input logic second);
    if (bm) return a == (second ? 12'h555 : 12'hAAA);
    else    return a[10:0] == (second ? 11'h2AA : 11'h555);
  endfunction

  function automatic logic [BUS_AW-1:0] word_index(input logic [BUS_AW-1:0] a,
                                                   input logic bm);
    return bm ? {1'b0, a[BUS_AW-1:1]} : a;
  endfunction

  // AND pattern applied to the stored word by a program.
  function automatic logic [WORD_W-1:0] prog_pattern(input logic [WORD_W-1:0] d,
                                                     input logic bm, input logic lane);
    if (!bm)  return d;
    if (lane) return {d[7:0], 8'hFF};
    return {8'hFF, d[7:0]};
  endfunction

  function automatic logic [WORD_W-1:0] byte_view(input logic [WORD_W-1:0] w,
                                                  input logic bm, input logic lane);
    if (!bm) return w;
    return {8'h00, lane ? w[15:8] : w[7:0]};
  endfunction

  function automatic id_slot_e id_slot(input logic [2:0] off, input logic bm);
    if (off == 3'd0) return ID_MFR;
    if (off == (bm ? 3'd2 : 3'd1)) return ID_DEV;
    if (off == (bm ? 3'd4 : 3'd2)) return ID_PROT;
    return ID_NONE;
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        wr_cmd,
  input  logic              byte_mode,
  output logic              id_mode,
  output logic              prog_fire
);

  seq_state_e st, nxt;

  logic at_first, at_second, cyc_key_a, cyc_key_b;
  assign at_first  = unlock_addr_hit(wr_addr, byte_mode, 1'b0);
  assign at_second = unlock_addr_hit(wr_addr, byte_mode, 1'b1);
  assign cyc_key_a = at_first  && (wr_cmd == CMD_KEY_A);
  assign cyc_key_b = at_second && (wr_cmd == CMD_KEY_B);

  always_comb begin
    nxt       = st;
    prog_fire = 1'b0;
    if (wr_acc) begin
      unique case (st)
        S_IDLE:  if (cyc_key_a) nxt = S_UNL1;
        S_UNL1:  nxt = cyc_key_b ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          nxt = S_IDLE;
          if (at_first) begin
            if (wr_cmd == CMD_IDENT)     nxt = S_AUTO;
            else if (wr_cmd == CMD_PROG) nxt = S_PSET;
            else if (wr_cmd == CMD_FAST) nxt = S_BYP;
          end
        end
        S_PSET: begin
          prog_fire = 1'b1;
          nxt       = S_IDLE;
        end
        S_AUTO:  if (wr_cmd == CMD_EXIT) nxt = S_IDLE;
        S_BYP: begin
          if (wr_cmd == CMD_PROG)       nxt = S_BPROG;
          else if (wr_cmd == CMD_IDENT) nxt = S_BRST;
        end
        S_BPROG: begin
          prog_fire = 1'b1;
          nxt       = S_BYP;
        end
        S_BRST:  nxt = (wr_cmd == CMD_FASTEND) ? S_IDLE : S_BYP;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  assign id_mode = (st == S_AUTO);

endmodule

// File: rtl/fcd_prog_engine.sv
module fcd_prog_engine
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BUS_AW-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_byte,
  output logic              prog_req,
  output logic              busy,
  output logic              commit,
  output logic [BUS_AW-1:0] prog_addr,
  output logic [WORD_W-1:0] prog_data,
  output logic              prog_byte
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      prog_byte <= 1'b0;
    end else begin
      prog_req <= fire;
      if (fire) begin
        cnt       <= CNT_LOAD;
        prog_addr <= in_addr;
        prog_data <= in_data;
        prog_byte <= in_byte;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign busy   = (cnt != '0);
  assign commit = (cnt == CNT_W'(1));

endmodule

// File: rtl/fcd_array.sv
module fcd_array
  import flash_cmd_pkg::*;
#(
  parameter int              ARR_AW    = 6,
  parameter int              SECT_W    = 2,
  parameter logic [15:0]     MFR_CODE  = 16'h0001,
  parameter logic [15:0]     DEV_CODE  = 16'h2A5B,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [BUS_AW-1:0] c_addr,
  input  logic [WORD_W-1:0] c_data,
  input  logic              c_byte,
  input  logic [BUS_AW-1:0] rd_addr,
  input  logic              byte_mode,
  input  logic              id_mode,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH  = 1 << ARR_AW;
  localparam int NSECT  = 1 << SECT_W;

  logic [WORD_W-1:0] row [DEPTH];

  logic [BUS_AW-1:0] c_wi, r_wi;
  logic [ARR_AW-1:0] c_idx, r_idx;
  logic [WORD_W-1:0] c_pat;
  assign c_wi  = word_index(c_addr, c_byte);
  assign r_wi  = word_index(rd_addr, byte_mode);
  assign c_idx = c_wi[ARR_AW-1:0];
  assign r_idx = r_wi[ARR_AW-1:0];
  assign c_pat = prog_pattern(c_data, c_byte, c_addr[0]);

  logic unused_hi;
  assign unused_hi = ^{c_wi[BUS_AW-1:ARR_AW], r_wi[BUS_AW-1:ARR_AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) row[i] <= '1;
    end else if (commit) begin
      row[c_idx] <= row[c_idx] & c_pat;
    end
  end

  // Per-sector protection status word, one generated entry per sector.
  logic [WORD_W-1:0] prot_word [NSECT];
  for (genvar g = 0; g < NSECT; g++) begin : g_prot
    assign prot_word[g] = {{(WORD_W-1){1'b0}}, PROT_MASK[g]};
  end

  logic [SECT_W-1:0] r_sect;
  id_slot_e          slot;
  logic [WORD_W-1:0] id_word, id_view, arr_view;
  assign r_sect = r_idx[ARR_AW-1 -: SECT_W];
  assign slot   = id_slot(rd_addr[2:0], byte_mode);

  always_comb begin
    unique case (slot)
      ID_MFR:  id_word = MFR_CODE;
      ID_DEV:  id_word = DEV_CODE;
      ID_PROT: id_word = prot_word[r_sect];
      default: id_word = '0;
    endcase
  end

  assign id_view  = byte_view(id_word, byte_mode, 1'b0);
  assign arr_view = byte_view(row[r_idx], byte_mode, rd_addr[0]);
  assign rd_data  = id_mode ? id_view : arr_view;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int          PROG_CYCLES = 4,
  parameter int          ARR_AW      = 6,
  parameter int          SECT_W      = 2,
  parameter logic [15:0] MFR_CODE    = 16'h0001,
  parameter logic [15:0] DEV_CODE    = 16'h2A5B,
  parameter logic [3:0]  PROT_MASK   = 4'b0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_mode,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic [11:0] rd_addr,
  output logic [15:0] rd_data,
  output logic        id_mode,
  output logic        prog_req,
  output logic [11:0] prog_addr,
  output logic [15:0] prog_data,
  output logic        busy
);

  logic wr_acc, prog_fire, commit, prog_byte;
  assign wr_acc = bus_we && !busy;

  fcd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (wr_acc),
    .wr_addr   (bus_addr),
    .wr_cmd    (bus_wdata[7:0]),
    .byte_mode (byte_mode),
    .id_mode   (id_mode),
    .prog_fire (prog_fire)
  );

  fcd_prog_engine #(.PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (prog_fire),
    .in_addr   (bus_addr),
    .in_data   (bus_wdata),
    .in_byte   (byte_mode),
    .prog_req  (prog_req),
    .busy      (busy),
    .commit    (commit),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .prog_byte (prog_byte)
  );

  fcd_array #(
    .ARR_AW    (ARR_AW),
    .SECT_W    (SECT_W),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE),
    .PROT_MASK (PROT_MASK[(1<<SECT_W)-1:0])
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .c_addr    (prog_addr),
    .c_data    (prog_data),
    .c_byte    (prog_byte),
    .rd_addr   (rd_addr),
    .byte_mode (byte_mode),
    .id_mode   (id_mode),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int PROG_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [7:0]  bus_cmd,
  input logic        busy,
  input logic        prog_req,
  input logic [11:0] prog_addr,
  input logic [15:0] prog_data,
  input logic        id_mode
);

  logic [15:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 16'd1;
    else           busy_run <= '0;
  end

  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_req) |-> ($stable(prog_addr) && $stable(prog_data)));

  a_r7_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (busy && !$past(busy)));

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 16'(PROG_CYCLES)));

  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 16'(PROG_CYCLES)));

  a_r3_enter_ident: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(bus_we && !busy && bus_cmd == 8'h90));

  a_r3_exit_ident: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(bus_we && !busy && bus_cmd == 8'hF0));

  a_r7_no_ident_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !id_mode);

endmodule

bind flash_cmd_fsm fcd_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_cmd   (bus_wdata[7:0]),
  .busy      (busy),
  .prog_req  (prog_req),
  .prog_addr (prog_addr),
  .prog_data (prog_data),
  .id_mode   (id_mode)
);

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;

  localparam int          P    = 4;
  localparam logic [15:0] MFR  = 16'h0001;
  localparam logic [15:0] DEV  = 16'h2A5B;
  localparam logic [3:0]  PROT = 4'b0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        id_mode, prog_req, busy;
  logic [11:0] prog_addr;
  logic [15:0] prog_data;

  int ntest = 0;
  int nfail = 0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  flash_cmd_fsm #(.PROG_CYCLES(P), .MFR_CODE(MFR), .DEV_CODE(DEV), .PROT_MASK(PROT)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .id_mode(id_mode), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [11:0] ua(input bit second);
    if (byte_mode) return second ? 12'h555 : 12'hAAA;
    return second ? 12'h2AA : 12'h555;
  endfunction

  task automatic unlock2(input logic [7:0] cmd);
    wr(ua(0), 16'h00AA);
    wr(ua(1), 16'h0055);
    wr(ua(0), {8'h00, cmd});
  endtask

  function automatic logic [15:0] rd_expect_arr(input int r);
    logic [15:0] w;
    if (!byte_mode) return model[r % 64];
    w = model[(r / 2) % 64];
    return {8'h00, (r % 2) ? w[15:8] : w[7:0]};
  endfunction

  function automatic logic [15:0] rd_expect_id(input int r);
    int off, wa, sect;
    logic [15:0] v;
    off  = r % 8;
    wa   = byte_mode ? r / 2 : r;
    sect = (wa % 64) / 16;
    v = 16'h0000;
    if (off == 0) v = MFR;
    else if (off == (byte_mode ? 2 : 1)) v = DEV;
    else if (off == (byte_mode ? 4 : 2)) v = {15'd0, PROT[sect]};
    return byte_mode ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic chk_rd(input string tag, input int r);
    rd_addr = 12'(r);
    #1;
    chk(tag, rd_data, id_mode ? rd_expect_id(r) : rd_expect_arr(r));
  endtask

  // Apply a program to the bench model: AND into the word / byte lane.
  task automatic model_prog(input logic [11:0] a, input logic [15:0] d, input bit bm);
    int wi;
    wi = (bm ? a / 2 : a) % 64;
    if (!bm)      model[wi] = model[wi] & d;
    else if (a[0]) model[wi] = model[wi] & {d[7:0], 8'hFF};
    else          model[wi] = model[wi] & {8'hFF, d[7:0]};
  endtask

  // Final data write of a program, then wait for engine completion.
  task automatic prog_tail(input string tag, input logic [11:0] a, input logic [15:0] d);
    wr(a, d);
    chk({tag, " R6 prog_req"}, prog_req, 1'b1);
    chk({tag, " R6 prog_addr"}, prog_addr, a);
    chk({tag, " R6 prog_data"}, prog_data, d);
    chk({tag, " R7 busy high"}, busy, 1'b1);
    model_prog(a, d, byte_mode);
    repeat (P) @(negedge clk);
    chk({tag, " R7 busy low after PROG_CYCLES"}, busy, 1'b0);
    chk_rd({tag, " R13 readback"}, byte_mode ? int'(a) : int'(a));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 id_mode", id_mode, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 prog_req", prog_req, 1'b0);
    for (int r = 0; r < 64; r++) chk_rd("R1 erased array", r);

    // R3/R4/R5 word-mode identification, full offset sweep
    unlock2(8'h90);
    chk("R3 id_mode entered (R2 word unlock)", id_mode, 1'b1);
    for (int r = 0; r < 64; r++) chk_rd("R4/R5 word id sweep", r);
    wr(12'h555, 16'h00AA);
    wr(12'h123, 16'h00A0);
    chk("R3 id_mode kept on non-F0 writes", id_mode, 1'b1);
    chk_rd("R4 mfr after extra writes", 0);
    wr(12'h3C7, 16'h12F0);
    chk("R3 F0 at any address exits", id_mode, 1'b0);
    chk_rd("R3 array read after exit", 1);

    // R2/R4/R5 byte-mode identification
    byte_mode = 1'b1;
    unlock2(8'h90);
    chk("R2 byte unlock enters id", id_mode, 1'b1);
    for (int r = 0; r < 128; r++) chk_rd("R4/R5 byte id sweep", r);
    wr(12'h000, 16'h00F0);
    chk("R3 byte exit", id_mode, 1'b0);
    // word-mode unlock addresses must not work in byte mode (R2)
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    chk("R2 word addresses rejected in byte mode", id_mode, 1'b0);
    byte_mode = 1'b0;

    // R6/R13 standard programs with several patterns
    for (int k = 0; k < 6; k++) begin
      logic [11:0] a;
      logic [15:0] d;
      a = 12'(k * 11 + 3);
      d = 16'hFFFF ^ (16'h1 << k) ^ (16'h0100 << (k % 8));
      unlock2(8'hA0);
      prog_tail("R6 std", a, d);
    end
    unlock2(8'hA0);
    prog_tail("R13 no 0->1", 12'd3, 16'hFFFF);

    // R7 collision: write sampled on the edge busy falls is dropped
    unlock2(8'hA0);
    prog_tail("R7 pre", 12'd40, 16'h5A5A);
    unlock2(8'hA0);
    wr(12'd41, 16'hF00F);
    model_prog(12'd41, 16'hF00F, 1'b0);
    repeat (P - 2) @(negedge clk);
    wr(12'h555, 16'h00AA);
    chk("R7 busy fell with colliding write", busy, 1'b0);
    wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    chk("R7 colliding unlock ignored", id_mode, 1'b0);
    unlock2(8'hA0);
    wr(12'd42, 16'h0FF0);
    model_prog(12'd42, 16'h0FF0, 1'b0);
    repeat (P - 1) @(negedge clk);
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    chk("R7 write one cycle later accepted", id_mode, 1'b1);
    wr(12'h000, 16'h00F0);
    chk_rd("R7 readback 41", 41);
    chk_rd("R7 readback 42", 42);

    // R11 aborted sequences: no program
    wr(12'h555, 16'h00AA); wr(12'h123, 16'h0055); wr(12'h555, 16'h00A0);
    wr(12'd7, 16'h0000);
    chk("R11 wrong addr no prog_req", prog_req, 1'b0);
    chk("R11 wrong addr no busy", busy, 1'b0);
    chk_rd("R11 array untouched", 7);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0056); wr(12'h555, 16'h00A0);
    wr(12'd8, 16'h0000);
    chk("R11 wrong data no busy", busy, 1'b0);
    chk_rd("R11 array untouched 8", 8);
    unlock2(8'h77);
    wr(12'd9, 16'h0000);
    chk("R11 unknown cmd no busy", busy, 1'b0);
    chk("R11 unknown cmd no id", id_mode, 1'b0);
    chk_rd("R11 array untouched 9", 9);

    // R8/R9/R10 fast-program mode
    unlock2(8'h20);
    chk("R8 fast mode not id", id_mode, 1'b0);
    for (int k = 0; k < 5; k++) begin
      wr(12'h000, 16'h00A0);
      prog_tail("R8 fast", 12'(50 + k), 16'hFFFF ^ (16'h0101 << k));
    end
    wr(12'h555, 16'h00AA);
    wr(12'd20, 16'h0000);
    chk("R9 other data ignored no busy", busy, 1'b0);
    chk_rd("R9 array untouched 20", 20);
    wr(12'h001, 16'h0090); wr(12'h001, 16'h0012);
    wr(12'h000, 16'h00A0);
    prog_tail("R9 still fast after 90/12", 12'd21, 16'h7E7E);
    wr(12'hABC, 16'h0090); wr(12'h321, 16'h0000);
    wr(12'h000, 16'h00A0); wr(12'd22, 16'h0000);
    chk("R10 exited fast mode no busy", busy, 1'b0);
    chk_rd("R10 array untouched 22", 22);

    // R12 byte-mode programs on both lanes
    byte_mode = 1'b1;
    for (int k = 0; k < 4; k++) begin
      unlock2(8'hA0);
      prog_tail("R12 byte", 12'(2 * (30 + k) + (k % 2)), {8'hEE, 8'h3C ^ 8'(k)});
    end
    for (int r = 60; r < 68; r++) chk_rd("R12 byte lanes", r);
    byte_mode = 1'b0;
    for (int r = 30; r < 34; r++) chk_rd("R12 word view of byte programs", r);

    summary();
    $finish;
  end

endmodule